// File: doc/BRIEF.md
# Programmable Periodic Down-Counter with Interrupt

This block is a down-counting timer that software controls through a small register window. Each register is one 32-bit word and is selected by a 3-bit word offset. A write strobe stores the data at the selected offset on the next clock edge. The read data is a combinational view of the register at the selected offset.

Software sets a start value and an 8-bit control byte. The control byte chooses:
- enable,
- periodic or free-running reload,
- one-shot halting,
- a 16-bit or 32-bit count width,
- a clock prescaler,
- interrupt masking.

Each time the count steps from one to zero, a sticky flag is set. The flag drives a level interrupt through the enable mask and stays set until software writes the clear register.

A second reload register lets software change the next period without touching the running count. Writes to the main load register restart the count at once.

Top module: `cdown_timer`

## Requirements
- R1: Word offsets decode as follows:
  - 0 is the load register (writes restart the count, reads return the reload value).
  - 1 reads the current count.
  - 2 is the control byte (read in bits 7:0, upper bits zero).
  - 3 is the clear register (reads zero).
  - 4 is the raw flag (bit 0).
  - 5 is the masked flag (bit 0).
  - 6 is the background reload (reads the reload value).
  - 7 reads zero.
  
  Writes to offsets 1, 4, 5 and 7 change nothing.
- R2: After reset, the control byte is 0, the flag is 0, and the reload value and the count are all ones. Because of R9, the count reads as 0x0000FFFF.
- R3: A write to offset 0 sets both the reload value and the count in the same edge, overriding any step in that cycle. A write to offset 6 sets only the reload value.
- R4: Control bit 7 enables stepping. While it is 0, the count and the prescaler hold.
- R5: Each prescaler tick lowers a nonzero count by one. A tick that takes the count from 1 to 0 sets the flag.
- R6: With control bit 6 = 1 (periodic), a tick at count zero reloads the count from the reload value.
- R7: With control bit 6 = 0 (free-running), a tick at count zero wraps the count to the maximum for the selected width.
- R8: With control bit 0 = 1 (one-shot), a tick at count zero leaves the count at zero, whatever bit 6 holds. The flag is therefore raised only once.
- R9: Control bit 1 = 1 selects a 32-bit count. Otherwise, stepping, the zero test and the offset-1 readback use only the low 16 bits.
- R10: Control bits 3:2 select the tick rate: 00 (and 11) every cycle, 01 every 16th cycle, 10 every 256th cycle. After enable is written at edge E, the first step happens at edge E+1, E+16 or E+256 respectively.
- R11: The flag stays set until a write of any value to offset 3. If that write lands in the same cycle as a 1-to-0 step, the flag stays set.
- R12: Control bit 5 masks the flag. The masked status and the `irq` output equal the flag AND bit 5, while the raw status shows the flag regardless of bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected word |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word |
| irq | output | 1 | Level interrupt, flag masked by enable |

## Verification
The two cases hardest to reach from the ports both depend on exact cycle alignment.

- **Clear colliding with a 1-to-0 step.** This needs the clear-register write to land on exactly the edge where the count steps from one to zero. The stimulus counts every bus slot from the enabling write, so a short periodic count reaches that step precisely when the clear is issued.
- **First tick under the 256 prescaler.** This only shows after a long idle run. The bench holds the bus idle for a computed number of slots and reads the count on both sides of the expected tick.

// File: rtl/cdown_pkg.sv
package cdown_pkg;

    localparam int unsigned ADDR_W = 3;

    // Control byte, bit 7 down to bit 0.
    typedef struct packed {
        logic       en;        // bit 7
        logic       periodic;  // bit 6
        logic       irq_en;    // bit 5
        logic       spare;     // bit 4
        logic [1:0] div;       // bits 3:2
        logic       wide;      // bit 1
        logic       single;    // bit 0
    } ctrl_t;

    localparam logic [ADDR_W-1:0] OFS_LOAD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_VALUE = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_BG    = 3'd6;

endpackage

// File: rtl/cdown_prescale.sv
module cdown_prescale #(
    parameter int unsigned DIV_MID  = 16,
    parameter int unsigned DIV_HIGH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] div,
    output logic       tick
);
    localparam int unsigned PW = $clog2(DIV_HIGH);
    localparam logic [PW-1:0] LIM_MID  = PW'(DIV_MID - 1);
    localparam logic [PW-1:0] LIM_HIGH = PW'(DIV_HIGH - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t          st_q, st_d;
    logic [PW-1:0] limit;

    always_comb begin
        unique case (div)
            2'b01:   limit = LIM_MID;
            2'b10:   limit = LIM_HIGH;
            default: limit = '0;
        endcase
        tick = run && (st_q.cnt >= limit);
        st_d = st_q;
        if (!run || restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cdown_count.sv
module cdown_count #(
    parameter int unsigned DW = 32,
    parameter int unsigned NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld_wr,
    input  logic [DW-1:0] ld_val,
    input  logic [DW-1:0] reload,
    input  logic          periodic,
    input  logic          single,
    input  logic          wide,
    input  logic          clr_wr,
    output logic [DW-1:0] cnt_q,
    output logic          flag_q
);
    localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          flag;
    } cnt_st_t;

    cnt_st_t       st_q, st_d;
    logic [DW-1:0] mask;
    logic [DW-1:0] cur;

    always_comb begin
        mask = wide ? '1 : NARROW_MASK;
        cur  = st_q.cnt & mask;
        st_d = st_q;
        if (clr_wr) begin
            st_d.flag = 1'b0;
        end
        if (ld_wr) begin
            st_d.cnt = ld_val;
        end else if (tick) begin
            if (cur == '0) begin
                if (single) begin
                    st_d.cnt = st_q.cnt;
                end else if (periodic) begin
                    st_d.cnt = reload;
                end else begin
                    st_d.cnt = mask;
                end
            end else begin
                st_d.cnt = cur - 1'b1;
                if (cur == DW'(1)) begin
                    st_d.flag = 1'b1;   // set beats a same-cycle clear
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q  = st_q.cnt;
    assign flag_q = st_q.flag;

endmodule

// File: rtl/cdown_regs.sv
module cdown_regs
    import cdown_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned NW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     cnt_q,
    input  logic              flag_q,
    output ctrl_t             ctrl_q,
    output logic [DW-1:0]     load_q,
    output logic              ld_wr,
    output logic              clr_wr,
    output logic [DW-1:0]     rdata
);
    localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};
    localparam int unsigned   CW          = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] load;
    } reg_st_t;

    reg_st_t       st_q, st_d;
    logic          bg_wr;
    logic [DW-1:0] mask;

    always_comb begin
        ld_wr  = wr_en && (addr == OFS_LOAD);
        bg_wr  = wr_en && (addr == OFS_BG);
        clr_wr = wr_en && (addr == OFS_CLR);
        st_d   = st_q;
        if (ld_wr || bg_wr) begin
            st_d.load = wdata;
        end
        if (wr_en && (addr == OFS_CTRL)) begin
            st_d.ctrl = ctrl_t'(wdata[CW-1:0]);
        end
    end

    always_comb begin
        mask = st_q.ctrl.wide ? '1 : NARROW_MASK;
        unique case (addr)
            OFS_LOAD, OFS_BG: rdata = st_q.load;
            OFS_VALUE:        rdata = cnt_q & mask;
            OFS_CTRL:         rdata = {{(DW-CW){1'b0}}, st_q.ctrl};
            OFS_RAW:          rdata = {{(DW-1){1'b0}}, flag_q};
            OFS_MSK:          rdata = {{(DW-1){1'b0}}, flag_q & st_q.ctrl.irq_en};
            default:          rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.load <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;
    assign load_q = st_q.load;

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
    import cdown_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned NW       = 16,
    parameter int unsigned DIV_MID  = 16,
    parameter int unsigned DIV_HIGH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] load_q;
    logic [DW-1:0] cnt_q;
    logic          flag_q;
    logic          ld_wr;
    logic          clr_wr;
    logic          tick;

    cdown_regs #(.DW(DW), .NW(NW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .cnt_q  (cnt_q),
        .flag_q (flag_q),
        .ctrl_q (ctrl_q),
        .load_q (load_q),
        .ld_wr  (ld_wr),
        .clr_wr (clr_wr),
        .rdata  (rdata)
    );

    cdown_prescale #(.DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.en),
        .restart (ld_wr),
        .div     (ctrl_q.div),
        .tick    (tick)
    );

    cdown_count #(.DW(DW), .NW(NW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ld_wr    (ld_wr),
        .ld_val   (wdata),
        .reload   (load_q),
        .periodic (ctrl_q.periodic),
        .single   (ctrl_q.single),
        .wide     (ctrl_q.wide),
        .clr_wr   (clr_wr),
        .cnt_q    (cnt_q),
        .flag_q   (flag_q)
    );

    assign irq = flag_q & ctrl_q.irq_en;

endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk
    import cdown_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned NW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input ctrl_t             ctrl_q,
    input logic [DW-1:0]     load_q,
    input logic [DW-1:0]     cnt_q,
    input logic              flag_q,
    input logic              tick
);
    localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

    logic [DW-1:0] mask_c;
    logic [DW-1:0] cur_c;
    logic          ld_c;
    logic          clr_c;

    assign mask_c = ctrl_q.wide ? '1 : NARROW_MASK;
    assign cur_c  = cnt_q & mask_c;
    assign ld_c   = wr_en && (addr == OFS_LOAD);
    assign clr_c  = wr_en && (addr == OFS_CLR);

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_c) |=> flag_q);

    p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(tick) && ($past(cur_c) == DW'(1))));

    p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !ld_c) |=> $stable(cnt_q));

    p_tick_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ctrl_q.en);

    p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.single && (cur_c == '0) && !ld_c) |=> $stable(cnt_q));

    p_free_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_q.single && !ctrl_q.periodic && (cur_c == '0) && !ld_c)
        |=> (cnt_q == $past(mask_c)));

    p_period_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_q.single && ctrl_q.periodic && (cur_c == '0) && !ld_c)
        |=> (cnt_q == $past(load_q)));

    p_irq_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q && ctrl_q.irq_en));

endmodule

bind cdown_timer cdown_timer_chk #(.DW(DW), .NW(NW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .irq    (irq),
    .ctrl_q (ctrl_q),
    .load_q (load_q),
    .cnt_q  (cnt_q),
    .flag_q (flag_q),
    .tick   (tick)
);

// File: tb/cdown_timer_test.sv
module cdown_timer_test;
    localparam int CLK_NS = 8;
    localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2, A_CLR = 3'd3,
                           A_RAW = 3'd4, A_MSK = 3'd5, A_BG = 3'd6, A_NONE = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rd_req = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        bit          chk_irq;
        logic        irq_exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #(CLK_NS/2) clk = ~clk;

    cdown_timer uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // Driver: each task call occupies one bus slot (one negedge to the next).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_req = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        rd_req = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd_x(input logic [2:0] a, input logic [31:0] e,
                        input bit ci, input logic ie, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0; addr = a; rd_req = 1'b1;
        it.exp = e; it.chk_irq = ci; it.irq_exp = ie; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        rd_x(a, e, 1'b0, 1'b0, tag);
    endtask

    // Monitor: samples mid-cycle, after the driver's negedge update.
    always @(negedge clk) begin
        #2;
        if (rd_req && !finished) begin
            if (sb.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: read with no expected item");
            end else begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
                end
                if (it.chk_irq) begin
                    n_checks++;
                    if (irq !== it.irq_exp) begin
                        n_fail++;
                        $display("FAIL %s: irq actual %b expected %b", it.tag, irq, it.irq_exp);
                    end
                end
            end
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        rd(A_CTRL, 32'h0, "R2 ctrl");
        rd(A_LOAD, 32'hFFFF_FFFF, "R2 load");
        rd(A_VAL, 32'h0000_FFFF, "R2 value");
        rd_x(A_RAW, 32'h0, 1'b1, 1'b0, "R2 flag");

        // R1: map, zero reads, ignored writes
        rd(A_CLR, 32'h0, "R1 clr reads 0");
        rd(A_NONE, 32'h0, "R1 offset 7");
        wr(A_VAL, 32'h55);
        wr(A_RAW, 32'h1);
        wr(A_MSK, 32'h1);
        rd(A_VAL, 32'h0000_FFFF, "R1 value write ignored");
        rd(A_RAW, 32'h0, "R1 status write ignored");
        wr(A_CTRL, 32'h0000_012C);
        rd(A_CTRL, 32'h0000_002C, "R1 ctrl readback");
        wr(A_CTRL, 32'h0);

        // R9: 16-bit readback masking
        wr(A_LOAD, 32'h0001_2345);
        rd(A_VAL, 32'h0000_2345, "R9 narrow value");
        rd(A_LOAD, 32'h0001_2345, "R1 load readback");
        wr(A_CTRL, 32'h02);
        rd(A_VAL, 32'h0001_2345, "R9 wide value");
        wr(A_CTRL, 32'h0);

        // R3: background reload, then periodic reload from it (R5, R6, R12)
        wr(A_LOAD, 32'd7);
        wr(A_BG, 32'd3);
        rd(A_VAL, 32'd7, "R3 bg write keeps count");
        rd(A_LOAD, 32'd3, "R3 reload value");
        rd(A_BG, 32'd3, "R1 bg readback");
        wr(A_CTRL, 32'hC0);                       // s0: enable, periodic, irq masked
        idle(7);                                  // e1..e7: 7 -> 0
        rd(A_VAL, 32'd0, "R5 reached zero");      // after e7
        rd(A_VAL, 32'd3, "R6 periodic reload");   // after e8
        rd_x(A_RAW, 32'd1, 1'b1, 1'b0, "R12 raw set, irq masked");
        rd_x(A_MSK, 32'd0, 1'b1, 1'b0, "R12 masked status off");
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h0);
        rd_x(A_RAW, 32'd0, 1'b1, 1'b0, "R11 cleared");
        rd(A_VAL, 32'd3, "R4 disabled holds");

        // Periodic with irq enabled, clear/step collision (R5, R6, R11, R12, R4)
        wr(A_LOAD, 32'd5);                        // s0
        wr(A_CTRL, 32'hE0);                       // s1
        rd(A_VAL, 32'd5, "R4 first step after enable edge");   // s2
        rd(A_VAL, 32'd4, "R5 step");              // s3
        rd_x(A_RAW, 32'd0, 1'b1, 1'b0, "R5 no flag before zero"); // s4
        rd(A_VAL, 32'd2, "R5 step");              // s5
        rd(A_VAL, 32'd1, "R5 step");              // s6
        rd_x(A_RAW, 32'd1, 1'b1, 1'b1, "R5 flag at zero");  // s7
        rd(A_VAL, 32'd5, "R6 reload");            // s8
        rd_x(A_MSK, 32'd1, 1'b1, 1'b1, "R12 masked status on"); // s9
        idle(1);                                  // s10
        rd_x(A_RAW, 32'd1, 1'b1, 1'b1, "R11 flag held");     // s11
        wr(A_CLR, 32'hFFFF_FFFF);                 // s12: same edge as 1 -> 0
        rd_x(A_RAW, 32'd1, 1'b1, 1'b1, "R11 set wins over clear"); // s13
        wr(A_CTRL, 32'h0);                        // s14
        wr(A_CLR, 32'h0);                         // s15
        rd_x(A_RAW, 32'd0, 1'b1, 1'b0, "R11 clear");
        rd(A_VAL, 32'd4, "R4 hold after disable");
        rd(A_VAL, 32'd4, "R4 hold after disable");

        // R8: one-shot halts at zero even with periodic set
        wr(A_LOAD, 32'd3);                        // s0
        wr(A_CTRL, 32'hE1);                       // s1
        idle(2);                                  // s2, s3
        rd(A_VAL, 32'd1, "R8 counting");          // s4
        rd_x(A_RAW, 32'd1, 1'b1, 1'b1, "R8 flag");// s5
        rd(A_VAL, 32'd0, "R8 halted");            // s6
        idle(1);
        rd(A_VAL, 32'd0, "R8 still halted");
        wr(A_CLR, 32'h0);
        rd_x(A_RAW, 32'd0, 1'b1, 1'b0, "R8 no second flag");
        rd(A_VAL, 32'd0, "R8 stays zero");
        wr(A_CTRL, 32'h0);

        // R7: free-running wrap, 16-bit then 32-bit (R9)
        wr(A_LOAD, 32'd1);
        wr(A_CTRL, 32'hA0);
        rd(A_VAL, 32'd1, "R7 before step");
        rd(A_VAL, 32'd0, "R7 zero");
        rd(A_VAL, 32'h0000_FFFF, "R7 narrow wrap");
        rd(A_VAL, 32'h0000_FFFE, "R9 narrow step");
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h0);
        wr(A_LOAD, 32'd1);
        wr(A_CTRL, 32'hA2);
        idle(1);
        rd(A_VAL, 32'd0, "R9 wide zero");
        rd(A_VAL, 32'hFFFF_FFFF, "R7 wide wrap");
        rd(A_VAL, 32'hFFFF_FFFE, "R9 wide step");
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h0);

        // R3: load write while running restarts at once
        wr(A_LOAD, 32'd50);                       // s0
        wr(A_CTRL, 32'h80);                       // s1
        idle(2);                                  // s2, s3
        wr(A_LOAD, 32'd20);                       // s4
        rd(A_VAL, 32'd20, "R3 immediate reload");
        rd(A_VAL, 32'd19, "R3 counts from new value");
        wr(A_CTRL, 32'h0);

        // R10: divide by 16
        wr(A_LOAD, 32'd100);                      // s0
        wr(A_CTRL, 32'h84);                       // s1
        idle(15);                                 // s2..s16
        rd(A_VAL, 32'd100, "R10 div16 before tick");  // s17
        rd(A_VAL, 32'd99, "R10 div16 first tick");    // s18
        idle(14);                                 // s19..s32
        rd(A_VAL, 32'd99, "R10 div16 before second"); // s33
        rd(A_VAL, 32'd98, "R10 div16 second tick");   // s34
        wr(A_CTRL, 32'h0);

        // R10: divide by 256
        wr(A_LOAD, 32'd100);
        wr(A_CTRL, 32'h88);
        idle(255);
        rd(A_VAL, 32'd100, "R10 div256 before tick");
        rd(A_VAL, 32'd99, "R10 div256 first tick");
        wr(A_CTRL, 32'h0);

        idle(3);
        if (sb.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        report();
    end

endmodule